// File: doc/BRIEF.md
# Complementary Switch-Pair Dead-Time and Minimum-Pulse Stage

This block sits between an ideal single-phase PWM demand signal and the two gate controls of one inverter leg: an upper switch tied to the positive DC rail and a lower switch tied to the negative rail. The upper output follows the demand and the lower output follows its inverse. Every turn-on is held back by a programmable dead interval, so that one switch has fully released before the other is commanded on. Turn-offs are not delayed.

Before the dead-time logic, a width qualifier removes demand levels that are too short for the power devices to handle. A demand level that differs from the accepted level must persist for a programmed number of carrier sub-ticks before it is accepted. Both edges of an accepted pulse are shifted by the same amount, so the pulse keeps its width, and a pulse that is too short never reaches the outputs. All timing is counted in sub-ticks, which arrive as a one-clock strobe from the carrier counter (one step of a 512-step carrier period). While reset is held low, both outputs are low.

Top module: `sw_pair_deadtime`

## Requirements
- R1: While `rst_ni` is low, `top_o` and `bot_o` are both 0.
- R2: `top_o` and `bot_o` are never 1 in the same cycle.
- R3: When the qualified demand goes low, `top_o` is 0 on the next clock; when it goes high, `bot_o` is 0 on the next clock. With `min_width_i` = 0, a falling `demand_i` sampled at one edge gives `top_o` = 0 after the second edge.
- R4: An output only starts counting its dead interval once the opposite output is already 0, so a rising output always follows a cycle in which the opposite output was 0.
- R5: The dead interval is pdy = 64 - `dly_code_i` sub-ticks: code 6'b111111 gives 1, 6'b111110 gives 2, and 6'b000000 gives 64. With a strobe on every clock, the number of cycles in which both outputs are 0 between the opposite output falling and this output rising equals pdy.
- R6: If the wanted level of an output goes away before its dead interval ends, the pending rise is dropped and the output stays 0.
- R7: With `min_width_i` = W > 0, a demand level that differs from the accepted level for fewer than W sub-ticks is ignored: the outputs do not change.
- R8: With `min_width_i` = W > 0, both edges of an accepted demand level are delayed by W sub-ticks, so the qualified pulse has the width of the demand pulse.
- R9: With `min_width_i` = 0, pulse deletion is off and the qualified demand is `demand_i` delayed by one clock.
- R10: Counters advance only in cycles with `tick_i` = 1; without strobes no output rises and the qualified level does not change while `min_width_i` > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; forces both outputs low |
| tick_i | input | 1 | Carrier sub-tick strobe, one clock wide |
| demand_i | input | 1 | Ideal PWM demand: 1 = upper switch on |
| dly_code_i | input | CODE_W (6) | Dead-time select, pdy = 64 - code |
| min_width_i | input | MINW_W (6) | Minimum pulse width in sub-ticks, 0 = no deletion |
| top_o | output | 1 | Upper switch gate control |
| bot_o | output | 1 | Lower switch gate control |

## Verification
Pulse deletion and dead-time cancellation can act in the same cycle. A qualified edge can arrive while a leg is still counting its dead interval, and a demand glitch can be cut by the qualifier in the same sub-tick as a leg's count expires. The bench provokes this with demand pulses whose length lies near the minimum width, and near the dead interval, together with sparse and irregular strobes and randomly changed codes. A behavioural model of both stages is compared with the outputs on every clock. Directed checks measure the dead interval at both code extremes, the kept pulse width, and the silence of the outputs during deleted pulses.

// File: rtl/sw_pair_pkg.sv
package sw_pair_pkg;

    // Role of one output leg of the switch pair.
    typedef enum logic {
        LEG_TOP = 1'b0,
        LEG_BOT = 1'b1
    } leg_role_e;

    // Leg state: released, or driving its switch.
    typedef enum logic {
        LEG_OFF = 1'b0,
        LEG_ON  = 1'b1
    } leg_state_e;

endpackage

// File: rtl/sw_pulse_qualifier.sv
module sw_pulse_qualifier #(
    parameter int MINW_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              demand_i,
    input  logic [MINW_W-1:0] minw_i,
    output logic              level_o
);

    typedef struct packed {
        logic              level;
        logic [MINW_W-1:0] cnt;
    } qual_t;

    qual_t q_q, q_d;
    logic [MINW_W-1:0] nxt_cnt;

    assign nxt_cnt = q_q.cnt + MINW_W'(1);

    always_comb begin
        q_d = q_q;
        if (minw_i == '0) begin
            // Deletion disabled: follow the demand directly.
            q_d.level = demand_i;
            q_d.cnt   = '0;
        end else if (demand_i == q_q.level) begin
            // Demand agrees with the accepted level: restart the hold count.
            q_d.cnt = '0;
        end else if (tick_i) begin
            if (nxt_cnt >= minw_i) begin
                q_d.level = demand_i;
                q_d.cnt   = '0;
            end else begin
                q_d.cnt = nxt_cnt;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign level_o = q_q.level;

endmodule

// File: rtl/sw_edge_delay_leg.sv
module sw_edge_delay_leg
    import sw_pair_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              want_i,
    input  logic              other_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              out_o
);

    localparam int CNT_W = CODE_W + 1;
    localparam logic [CNT_W-1:0] FULL_SPAN = CNT_W'(1 << CODE_W);

    typedef struct packed {
        leg_state_e       st;
        logic [CNT_W-1:0] cnt;
    } leg_t;

    leg_t q_q, q_d;
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] nxt_cnt;

    // Inverted code: all ones -> 1 tick, all zeros -> FULL_SPAN ticks.
    assign span    = FULL_SPAN - {1'b0, code_i};
    assign nxt_cnt = q_q.cnt + CNT_W'(1);

    always_comb begin
        q_d = q_q;
        if (!want_i) begin
            // Falling edge passes at once; any pending rise is dropped.
            q_d.st  = LEG_OFF;
            q_d.cnt = '0;
        end else if (q_q.st == LEG_OFF && tick_i && !other_i) begin
            if (nxt_cnt >= span) begin
                q_d.st  = LEG_ON;
                q_d.cnt = '0;
            end else begin
                q_d.cnt = nxt_cnt;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '{st: LEG_OFF, cnt: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign out_o = (q_q.st == LEG_ON);

endmodule

// File: rtl/sw_pair_deadtime.sv
module sw_pair_deadtime
    import sw_pair_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int MINW_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              demand_i,
    input  logic [CODE_W-1:0] dly_code_i,
    input  logic [MINW_W-1:0] min_width_i,
    output logic              top_o,
    output logic              bot_o
);

    localparam int NUM_LEGS = 2;

    logic                qual_lvl;
    logic [NUM_LEGS-1:0] leg_out;

    sw_pulse_qualifier #(
        .MINW_W(MINW_W)
    ) u_qual (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .demand_i(demand_i),
        .minw_i  (min_width_i),
        .level_o (qual_lvl)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        localparam leg_role_e ROLE = (g == 0) ? LEG_TOP : LEG_BOT;
        logic want;
        assign want = (ROLE == LEG_TOP) ? qual_lvl : ~qual_lvl;

        sw_edge_delay_leg #(
            .CODE_W(CODE_W)
        ) u_leg (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .tick_i (tick_i),
            .want_i (want),
            .other_i(leg_out[NUM_LEGS-1-g]),
            .code_i (dly_code_i),
            .out_o  (leg_out[g])
        );
    end

    assign top_o = leg_out[0];
    assign bot_o = leg_out[1];

endmodule

// File: rtl/sw_pair_deadtime_chk.sv
module sw_pair_deadtime_chk #(
    parameter int MINW_W = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              demand_i,
    input logic [MINW_W-1:0] min_width_i,
    input logic              qual_i,
    input logic              top_o,
    input logic              bot_o
);

    logic seen_edge;
    always_ff @(posedge clk_i) seen_edge <= 1'b1;

    always @(negedge clk_i) begin
        if (seen_edge === 1'b1 && !rst_ni) begin
            AST_RESET_LOW: assert (!top_o && !bot_o); // R1
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(top_o && bot_o)); // R2

    AST_TOP_FALL_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !qual_i |=> !top_o); // R3

    AST_BOT_FALL_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qual_i |=> !bot_o); // R3

    AST_TOP_AFTER_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(top_o) |-> !$past(bot_o)); // R4

    AST_BOT_AFTER_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bot_o) |-> !$past(top_o)); // R4

    AST_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(top_o) || $rose(bot_o)) |-> $past(tick_i)); // R10

    AST_QUAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (min_width_i != '0 && !tick_i) |=> $stable(qual_i)); // R7

    AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (min_width_i == '0) |=> (qual_i == $past(demand_i))); // R9

endmodule

bind sw_pair_deadtime sw_pair_deadtime_chk #(
    .MINW_W(MINW_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .demand_i   (demand_i),
    .min_width_i(min_width_i),
    .qual_i     (qual_lvl),
    .top_o      (top_o),
    .bot_o      (bot_o)
);

// File: tb/sw_pair_deadtime_bench.sv
`timescale 1ns/1ps
module sw_pair_deadtime_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       demand = 1'b0;
    logic [5:0] code = 6'd63;
    logic [5:0] minw = 6'd0;
    logic       top, bot;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_per = 1;     // 0: no strobes, 1: every clock, N: every Nth, -1: random
    bit compare_on = 0;
    bit finished = 0;
    string cur_req = "R1";

    // reference model state
    int m_q = 0, m_f = 0, m_t = 0, m_b = 0, m_tc = 0, m_bc = 0;

    always #2.5 clk = ~clk;

    sw_pair_deadtime u_sw_pair_deadtime (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .demand_i   (demand),
        .dly_code_i (code),
        .min_width_i(minw),
        .top_o      (top),
        .bot_o      (bot)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Behavioural model, updated on the clock from the stable inputs.
    always @(posedge clk) begin
        int pdy, nq, nf, nt, nb, ntc, nbc;
        if (!rst_n) begin
            m_q = 0; m_f = 0; m_t = 0; m_b = 0; m_tc = 0; m_bc = 0;
        end else begin
            pdy = 64 - int'(code);
            nq = m_q; nf = m_f;
            if (minw == 0) begin
                nq = demand; nf = 0;
            end else if (int'(demand) == m_q) begin
                nf = 0;
            end else if (tick) begin
                nf = m_f + 1;
                if (nf >= int'(minw)) begin nq = demand; nf = 0; end
            end
            nt = m_t; ntc = m_tc; nb = m_b; nbc = m_bc;
            if (m_q == 0) begin nt = 0; ntc = 0; end
            else if (m_t == 0 && tick && m_b == 0) begin
                ntc = m_tc + 1;
                if (ntc >= pdy) begin nt = 1; ntc = 0; end
            end
            if (m_q == 1) begin nb = 0; nbc = 0; end
            else if (m_b == 0 && tick && m_t == 0) begin
                nbc = m_bc + 1;
                if (nbc >= pdy) begin nb = 1; nbc = 0; end
            end
            m_q = nq; m_f = nf; m_t = nt; m_tc = ntc; m_b = nb; m_bc = nbc;
        end
    end

    // Compare on every clock, then drive the strobe for the next one.
    always @(negedge clk) begin
        cyc++;
        if (compare_on) begin
            check(cur_req, int'(top), m_t, "top_o vs model");
            check(cur_req, int'(bot), m_b, "bot_o vs model");
            if (top && bot) check("R2", 1, 0, "both outputs high");
        end
        case (tick_per)
            0:       tick <= 1'b0;
            -1:      tick <= ($urandom_range(0, 2) != 0);
            default: tick <= ((cyc % tick_per) == 0);
        endcase
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Measure cycles with both outputs low after bot falls until top rises.
    task automatic measure_dead(input logic [5:0] c, input int exp_pdy);
        int gap = 0;
        int lim = 0;
        code = c; minw = 0; tick_per = 1; demand = 1'b0;
        wait_clk(80);
        demand = 1'b1;
        while (bot && lim < 10) begin wait_clk(1); lim++; end
        while (!top && lim < 200) begin
            if (!bot) gap++;
            wait_clk(1); lim++;
        end
        check("R5", gap, exp_pdy, $sformatf("dead interval for code %0d", c));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int seen_top, seen_bot_low, hi_cnt;
        // R1: reset holds both low even with demand toggling and strobes.
        cur_req = "R1";
        compare_on = 1;
        for (int i = 0; i < 6; i++) begin
            demand = i[0];
            wait_clk(1);
            check("R1", int'(top) + int'(bot), 0, "outputs during reset");
        end
        demand = 1'b0;
        rst_n = 1'b1;

        // R5: code mapping at the extremes and in between.
        cur_req = "R5";
        measure_dead(6'b111111, 1);
        measure_dead(6'b111110, 2);
        measure_dead(6'b000000, 64);
        measure_dead(6'd40, 24);

        // R3: a falling demand reaches top_o after two edges.
        cur_req = "R3";
        code = 6'd63; minw = 0; tick_per = 1;
        wait_clk(10);
        check("R3", int'(top), 1, "top high before fall");
        demand = 1'b0;
        wait_clk(1);
        check("R3", int'(top), 1, "top one edge after fall");
        wait_clk(1);
        check("R3", int'(top), 0, "top two edges after fall");

        // R6: demand pulse shorter than the dead interval is cancelled.
        cur_req = "R6";
        code = 6'd0; demand = 1'b0;
        wait_clk(80);
        seen_top = 0;
        demand = 1'b1;
        for (int i = 0; i < 20; i++) begin wait_clk(1); seen_top |= top; end
        demand = 1'b0;
        for (int i = 0; i < 90; i++) begin wait_clk(1); seen_top |= top; end
        check("R6", seen_top, 0, "top after cancelled rise");

        // R7: pulses below minimum width leave the outputs untouched.
        cur_req = "R7";
        code = 6'd63; minw = 6'd12;
        wait_clk(20);
        seen_top = 0; seen_bot_low = 0;
        for (int p = 1; p < 12; p++) begin
            demand = 1'b1;
            for (int i = 0; i < p; i++) begin wait_clk(1); seen_top |= top; seen_bot_low |= !bot; end
            demand = 1'b0;
            for (int i = 0; i < 15; i++) begin wait_clk(1); seen_top |= top; seen_bot_low |= !bot; end
        end
        check("R7", seen_top, 0, "top during deleted pulses");
        check("R7", seen_bot_low, 0, "bot dropped during deleted pulses");

        // R8: an accepted pulse keeps its width (30 clocks -> top high 30 - pdy).
        cur_req = "R8";
        minw = 6'd8; code = 6'd63;
        wait_clk(20);
        hi_cnt = 0;
        demand = 1'b1;
        for (int i = 0; i < 30; i++) begin wait_clk(1); hi_cnt += top; end
        demand = 1'b0;
        for (int i = 0; i < 30; i++) begin wait_clk(1); hi_cnt += top; end
        check("R8", hi_cnt, 29, "top high cycles for 30-clock pulse");

        // R9: with deletion off, a 3-clock pulse still produces a top pulse.
        cur_req = "R9";
        minw = 6'd0;
        wait_clk(20);
        seen_top = 0;
        demand = 1'b1;
        wait_clk(3);
        demand = 1'b0;
        for (int i = 0; i < 4; i++) begin wait_clk(1); seen_top |= top; end
        check("R9", seen_top, 1, "top pulse with deletion off");

        // R10: without strobes nothing rises; strobes then release it.
        cur_req = "R10";
        wait_clk(20);
        tick_per = 0;
        wait_clk(2);
        demand = 1'b1;
        wait_clk(20);
        check("R10", int'(top), 0, "top without strobes");
        check("R10", int'(bot), 0, "bot after fall without strobes");
        tick_per = 1;
        wait_clk(4);
        check("R10", int'(top), 1, "top once strobes resume");

        // R2/R4/R6/R7: random demand near both thresholds, irregular strobes.
        cur_req = "R4";
        tick_per = -1;
        for (int blk = 0; blk < 40; blk++) begin
            code = 6'($urandom_range(40, 63));
            minw = 6'($urandom_range(0, 6));
            for (int i = 0; i < 60; i++) begin
                if ($urandom_range(0, 4) == 0) demand = ~demand;
                wait_clk(1);
            end
        end
        cur_req = "R2";
        tick_per = 3;
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 9) == 0) demand = ~demand;
            if ($urandom_range(0, 199) == 0) code = 6'($urandom);
            wait_clk(1);
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule